// File: doc/BRIEF.md
# Indirect Configuration Port with Internal Bus Master

This block puts an internal bus master behind a two-register configuration port. A host that can only make byte-wide I/O accesses writes a register number into an index port and then reads or writes the selected register through a data port. Before any of that is accepted, the configuration space must be opened with a two-byte password on the index port, and it can be closed again with a single byte.

Inside the opened space, one register chooses a logical device, and an enable bit switches the bridge device on. Once the bridge device is chosen and enabled, the host builds a bus address and a data word one byte at a time, picks the access size, and starts exactly one single-beat cycle on the internal bus. A specific byte written to the trigger register starts a write. Any read of the trigger register starts a read, and the returned word then appears in the data bytes, most significant byte first. A busy flag holds the request until the internal bus acknowledges it. Retriggers and register writes that arrive while the cycle is pending are dropped.

The host side is a flat strobe interface. `io_sel` low addresses the index port (I/O 0x2E) and high addresses the data port (I/O 0x2F). Decoding of the host bus itself and every other logical device lie outside the block.

Top module: `cfgb_bridge`

## Requirements
- R1: The space opens only after two consecutive index-port writes of 0xA5. Before that, every data-port read and every index-port read returns 0xFF.
- R2: If a single 0xA5 is followed by any other index-port byte, the password sequence restarts, so one further 0xA5 does not open the space.
- R3: An index-port write of 0xAA while open closes the space. The index register keeps its previous value, and reads return 0xFF again.
- R4: While closed, index-port writes other than the password and all data-port writes change no register, and no bus cycle starts.
- R5: When open, an index-port read returns the selected register number. Register 0x07 holds the logical device and reads back. Register 0x30 bit 0 is the device enable and is reachable only while device 0x0D is chosen. Registers 0xF0–0xF8 and 0xFE respond only while device 0x0D is chosen and enabled. Otherwise they read 0xFF and ignore writes. Unlisted registers read 0xFF.
- R6: Registers 0xF0..0xF3 form the bus address and 0xF4..0xF7 the data word, the lower register number being the more significant byte. `bus_size` carries bits 1:0 of register 0xF8, where 2 means a 4-byte access.
- R7: Writing 0xCF to register 0xFE starts a bus write with the assembled address, data and size. Any other value written there starts nothing.
- R8: Reading register 0xFE starts a bus read and returns 0x00 when idle (bit 0 is the busy flag). The acknowledged word is loaded into 0xF4..0xF7 with its most significant byte in 0xF4.
- R9: `bus_req` rises in the cycle after the trigger. It stays high with stable address, data, size and direction until `bus_ack` is sampled high, and it is low in the next cycle. `bus_ack` while idle has no effect.
- R10: While busy, further triggers and writes to 0xF0–0xF8 are ignored. Reads of 0xF4..0xF7 return the contents from before the pending read, and a read of 0xFE returns 0x01.
- R11: `io_rdata` takes the selected register's value at the edge that samples `io_rd` and holds it until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_sel | input | 1 | 0 = index port, 1 = data port |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, registered |
| bus_req | output | 1 | Internal bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 32 | Internal bus address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_size | output | 2 | Access size code |
| bus_ack | input | 1 | Internal bus acknowledge, one cycle |
| bus_rdata | input | 32 | Internal bus read data, valid with bus_ack |

## Verification
A host strobe sampled at edge N shows up on `io_rdata` and in every register from edge N on. A trigger sampled at edge N drives `bus_req` high from edge N. An acknowledge sampled at edge M drops `bus_req` and loads the read word at edge M, so a data read strobed in the next cycle returns it. The bench holds a behavioural model that is updated at each rising edge from the same input values the design samples. On every falling edge it compares `io_rdata` and all bus outputs with the model, so a result one cycle early or late is reported in the cycle it goes wrong.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam logic [7:0] KEY_OPEN    = 8'hA5;
  localparam logic [7:0] KEY_CLOSE   = 8'hAA;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_EN      = 8'h30;
  localparam logic [7:0] IDX_ADDR0   = 8'hF0;
  localparam logic [7:0] IDX_DATA0   = 8'hF4;
  localparam logic [7:0] IDX_SIZE    = 8'hF8;
  localparam logic [7:0] IDX_TRIG    = 8'hFE;
  localparam logic [7:0] LDN_BRIDGE  = 8'h0D;
  localparam logic [7:0] TRIG_WR_KEY = 8'hCF;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_st_t;
endpackage

// File: rtl/cfgb_unlock.sv
module cfgb_unlock
  import cfgb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wbyte,
  output logic       unlocked
);
  lock_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      case (st_q)
        LK_CLOSED: st_d = (wbyte == KEY_OPEN) ? LK_HALF : LK_CLOSED;
        LK_HALF:   st_d = (wbyte == KEY_OPEN) ? LK_OPEN : LK_CLOSED;
        LK_OPEN:   st_d = (wbyte == KEY_CLOSE) ? LK_CLOSED : LK_OPEN;
        default:   st_d = LK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_CLOSED;
    else if (idx_wr) st_q <= st_d;
  end

  assign unlocked = (st_q == LK_OPEN);

  assert_open_needs_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(idx_wr && (wbyte == KEY_OPEN)));

  assert_close_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && idx_wr && (wbyte == KEY_CLOSE)) |=> !unlocked);
endmodule

// File: rtl/cfgb_regs.sv
module cfgb_regs
  import cfgb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlocked,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_word,
  output logic [7:0]        io_rdata,
  output logic              trig_wr,
  output logic              trig_rd,
  output logic [ADDR_W-1:0] addr_word,
  output logic [DATA_W-1:0] data_word,
  output logic [SIZE_W-1:0] size_sel
);
  localparam int AB = ADDR_W / 8;
  localparam int DB = DATA_W / 8;

  logic [7:0]        idx_q, ldn_q, size_q, rdata_q, rd_val;
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              data_wr, data_rd, idx_we, ldn_we, en_we, size_we;
  logic              bridge_sel, bridge_on, reg_open;

  assign data_wr    = io_wr && io_sel && unlocked;
  assign data_rd    = io_rd && io_sel && unlocked;
  assign idx_we     = io_wr && !io_sel && unlocked && (io_wdata != KEY_CLOSE);
  assign bridge_sel = (ldn_q == LDN_BRIDGE);
  assign bridge_on  = bridge_sel && en_q;
  assign reg_open   = bridge_on && !busy;
  assign ldn_we     = data_wr && (idx_q == IDX_LDN);
  assign en_we      = data_wr && (idx_q == IDX_EN) && bridge_sel;
  assign size_we    = data_wr && reg_open && (idx_q == IDX_SIZE);
  assign trig_wr    = data_wr && reg_open && (idx_q == IDX_TRIG) && (io_wdata == TRIG_WR_KEY);
  assign trig_rd    = data_rd && reg_open && (idx_q == IDX_TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_we) idx_q <= io_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldn_q <= '0;
    else if (ldn_we) ldn_q <= io_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (en_we) en_q <= io_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= '0;
    else if (size_we) size_q <= io_wdata;
  end

  for (genvar k = 0; k < AB; k++) begin : g_addr
    logic hit;
    assign hit = data_wr && reg_open && (idx_q == 8'(IDX_ADDR0 + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q[ADDR_W-1-8*k -: 8] <= '0;
      else if (hit) addr_q[ADDR_W-1-8*k -: 8] <= io_wdata;
    end
  end

  for (genvar k = 0; k < DB; k++) begin : g_data
    logic       hit, load;
    logic [7:0] nxt;
    assign hit  = data_wr && reg_open && (idx_q == 8'(IDX_DATA0 + k));
    assign load = hit || rd_done;
    assign nxt  = rd_done ? rd_word[DATA_W-1-8*k -: 8] : io_wdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q[DATA_W-1-8*k -: 8] <= '0;
      else if (load) data_q[DATA_W-1-8*k -: 8] <= nxt;
    end
  end

  always_comb begin
    rd_val = IDLE_BYTE;
    if (unlocked) begin
      if (!io_sel) begin
        rd_val = idx_q;
      end else if (idx_q == IDX_LDN) begin
        rd_val = ldn_q;
      end else if (idx_q == IDX_EN) begin
        if (bridge_sel) rd_val = {7'b0, en_q};
      end else if (bridge_on) begin
        if (idx_q == IDX_SIZE) rd_val = size_q;
        if (idx_q == IDX_TRIG) rd_val = {7'b0, busy};
        for (int k = 0; k < AB; k++)
          if (idx_q == 8'(IDX_ADDR0 + k)) rd_val = addr_q[ADDR_W-1-8*k -: 8];
        for (int k = 0; k < DB; k++)
          if (idx_q == 8'(IDX_DATA0 + k)) rd_val = data_q[DATA_W-1-8*k -: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (io_rd) rdata_q <= rd_val;
  end

  assign io_rdata  = rdata_q;
  assign addr_word = addr_q;
  assign data_word = data_q;
  assign size_sel  = size_q[SIZE_W-1:0];

  assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !unlocked) |=> (io_rdata == IDLE_BYTE));

  assert_hold_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_word));
endmodule

// File: rtl/cfgb_master.sv
module cfgb_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_wr,
  input  logic              trig_rd,
  input  logic [ADDR_W-1:0] addr_word,
  input  logic [DATA_W-1:0] data_word,
  input  logic [SIZE_W-1:0] size_sel,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [SIZE_W-1:0] bus_size,
  output logic              busy,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_word
);
  logic              busy_q, busy_d, start;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [SIZE_W-1:0] size_q;

  assign start = !busy_q && (trig_wr || trig_rd);

  always_comb begin
    busy_d = busy_q;
    if (busy_q && bus_ack) busy_d = 1'b0;
    else if (start)        busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
    end else if (start) begin
      we_q    <= trig_wr;
      addr_q  <= addr_word;
      wdata_q <= data_word;
      size_q  <= size_sel;
    end
  end

  assign bus_req   = busy_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_size  = size_q;
  assign busy      = busy_q;
  assign rd_done   = busy_q && bus_ack && !we_q;
  assign rd_word   = bus_rdata;

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req);

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);

  assert_cycle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

  assert_no_trig_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr || trig_rd) |-> !busy_q);
endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [SIZE_W-1:0] bus_size,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic              unlocked, busy, rd_done, trig_wr, trig_rd;
  logic [DATA_W-1:0] rd_word, data_word;
  logic [ADDR_W-1:0] addr_word;
  logic [SIZE_W-1:0] size_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  cfgb_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .idx_wr   (io_wr && !io_sel),
    .wbyte    (io_wdata),
    .unlocked (unlocked)
  );

  cfgb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .unlocked  (unlocked),
    .io_sel    (io_sel),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .busy      (busy),
    .rd_done   (rd_done),
    .rd_word   (rd_word),
    .io_rdata  (io_rdata),
    .trig_wr   (trig_wr),
    .trig_rd   (trig_rd),
    .addr_word (addr_word),
    .data_word (data_word),
    .size_sel  (size_sel)
  );

  cfgb_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_master (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .trig_wr   (trig_wr),
    .trig_rd   (trig_rd),
    .addr_word (addr_word),
    .data_word (data_word),
    .size_sel  (size_sel),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_size  (bus_size),
    .busy      (busy),
    .rd_done   (rd_done),
    .rd_word   (rd_word)
  );
endmodule

// File: tb/cfgb_bridge_test.sv
module cfgb_bridge_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] RD_SALT = 32'h5A5A_0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_sel = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  cfgb_bridge uut (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  int    checks = 0, errors = 0;
  string cur_req = "R11";
  bit    finished = 0;
  int    lat = 3, wcnt = 0;
  bit    spur = 0;

  // behavioural model
  int         m_st;
  logic [7:0] m_idx, m_ldn, m_size, m_rdata;
  bit         m_en, m_busy, m_bwe;
  logic [7:0] m_addr[4];
  logic [7:0] m_dat[4];
  logic [31:0] m_baddr, m_bwdata;
  logic [1:0]  m_bsize;

  function automatic logic [7:0] model_read(bit was_busy);
    bit on;
    on = (m_ldn == 8'h0D) && m_en;
    if (m_st != 2) return 8'hFF;
    if (!io_sel) return m_idx;
    if (m_idx == 8'h07) return m_ldn;
    if (m_idx == 8'h30) return (m_ldn == 8'h0D) ? {7'b0, m_en} : 8'hFF;
    if (!on) return 8'hFF;
    if (m_idx >= 8'hF0 && m_idx <= 8'hF3) return m_addr[m_idx - 8'hF0];
    if (m_idx >= 8'hF4 && m_idx <= 8'hF7) return m_dat[m_idx - 8'hF4];
    if (m_idx == 8'hF8) return m_size;
    if (m_idx == 8'hFE) return {7'b0, was_busy};
    return 8'hFF;
  endfunction

  task automatic model_start(bit we);
    m_busy  = 1;
    m_bwe   = we;
    m_baddr = {m_addr[0], m_addr[1], m_addr[2], m_addr[3]};
    m_bwdata = {m_dat[0], m_dat[1], m_dat[2], m_dat[3]};
    m_bsize = m_size[1:0];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_ldn = 0; m_size = 0; m_rdata = 0;
      m_en = 0; m_busy = 0; m_bwe = 0; m_baddr = 0; m_bwdata = 0; m_bsize = 0;
      for (int i = 0; i < 4; i++) begin m_addr[i] = 0; m_dat[i] = 0; end
    end else begin
      bit was_busy, open, on;
      was_busy = m_busy;
      open = (m_st == 2);
      on = (m_ldn == 8'h0D) && m_en;
      if (io_rd) begin
        m_rdata = model_read(was_busy);
        if (open && io_sel && on && !was_busy && m_idx == 8'hFE) model_start(0);
      end
      if (io_wr && !io_sel) begin
        if (!open) m_st = (io_wdata == 8'hA5) ? ((m_st == 1) ? 2 : 1) : 0;
        else if (io_wdata == 8'hAA) m_st = 0;
        else m_idx = io_wdata;
      end
      if (io_wr && io_sel && open) begin
        if (m_idx == 8'h07) m_ldn = io_wdata;
        else if (m_idx == 8'h30) begin if (m_ldn == 8'h0D) m_en = io_wdata[0]; end
        else if (on && !was_busy) begin
          if (m_idx >= 8'hF0 && m_idx <= 8'hF3) m_addr[m_idx - 8'hF0] = io_wdata;
          if (m_idx >= 8'hF4 && m_idx <= 8'hF7) m_dat[m_idx - 8'hF4] = io_wdata;
          if (m_idx == 8'hF8) m_size = io_wdata;
          if (m_idx == 8'hFE && io_wdata == 8'hCF) model_start(1);
        end
      end
      if (bus_ack && was_busy) begin
        m_busy = 0;
        if (!m_bwe)
          for (int i = 0; i < 4; i++) m_dat[i] = bus_rdata[31-8*i -: 8];
      end
    end
  end

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(bus_req === m_busy, "bus_req", 32'(bus_req), 32'(m_busy));
      if (m_busy) begin
        check(bus_we === m_bwe, "bus_we", 32'(bus_we), 32'(m_bwe));
        check(bus_addr === m_baddr, "bus_addr", bus_addr, m_baddr);
        check(bus_wdata === m_bwdata || !m_bwe, "bus_wdata", bus_wdata, m_bwdata);
        check(bus_size === m_bsize, "bus_size", 32'(bus_size), 32'(m_bsize));
      end
      check(io_rdata === m_rdata, "io_rdata", 32'(io_rdata), 32'(m_rdata));
    end
  end

  // internal bus responder
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 0; wcnt = 0;
    end else if (bus_req) begin
      if (wcnt >= lat) begin bus_ack = 1; bus_rdata = bus_addr ^ RD_SALT; end
      else wcnt++;
    end else if (spur) begin
      bus_ack = 1; bus_rdata = 32'hDEAD_BEEF;
    end
  end

  task automatic io_op(bit sel, bit wr, logic [7:0] b);
    io_sel = sel; io_wr = wr; io_rd = !wr; io_wdata = b;
    @(negedge clk);
    io_wr = 0; io_rd = 0; io_wdata = 0;
  endtask
  task automatic idx_w(logic [7:0] b); io_op(0, 1, b); endtask
  task automatic idx_r(); io_op(0, 0, 8'h00); endtask
  task automatic dat_w(logic [7:0] b); io_op(1, 1, b); endtask
  task automatic dat_r(); io_op(1, 0, 8'h00); endtask
  task automatic reg_w(logic [7:0] r, logic [7:0] b); idx_w(r); dat_w(b); endtask
  task automatic reg_r(logic [7:0] r); idx_w(r); dat_r(); endtask
  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur_req = "R4";       // closed: writes ignored, reads 0xFF
    idx_w(8'h07); dat_w(8'h0D); dat_r(); idx_r();
    idx_w(8'hFE); dat_w(8'hCF); dat_r(); idle_wait(3);

    cur_req = "R2";       // broken password
    idx_w(8'hA5); idx_w(8'h12); idx_w(8'hA5); dat_r(); idx_r();

    cur_req = "R1";       // proper password
    idx_w(8'hA5); idx_w(8'hA5); idx_r(); reg_r(8'h07); idx_r();

    cur_req = "R5";       // device select and enable gating
    reg_w(8'h07, 8'h0D); dat_r();
    reg_w(8'hF0, 8'h44); dat_r();          // not enabled yet: FF, ignored
    reg_r(8'h30);
    reg_w(8'h30, 8'h01); dat_r();
    reg_r(8'hF0);
    reg_w(8'h07, 8'h02); reg_r(8'h30); reg_r(8'hF0); reg_r(8'h55);
    reg_w(8'h07, 8'h0D); reg_r(8'h42);

    cur_req = "R6";       // address, data and size bytes
    reg_w(8'hF0, 8'h12); reg_w(8'hF1, 8'h34); reg_w(8'hF2, 8'h56); reg_w(8'hF3, 8'h78);
    reg_w(8'hF4, 8'hCA); reg_w(8'hF5, 8'hFE); reg_w(8'hF6, 8'hBA); reg_w(8'hF7, 8'hBE);
    reg_w(8'hF8, 8'h02); dat_r(); reg_r(8'hF2); reg_r(8'hF5);

    cur_req = "R7";       // wrong key, then write trigger
    reg_w(8'hFE, 8'h55); idle_wait(2);
    lat = 4;
    reg_w(8'hFE, 8'hCF);

    cur_req = "R10";      // while busy
    dat_w(8'hCF); reg_w(8'hF0, 8'h99); dat_r(); reg_r(8'hFE);
    cur_req = "R9";
    wait_idle();
    cur_req = "R10";
    reg_r(8'hF0); reg_r(8'hFE);

    cur_req = "R8";       // read trigger
    lat = 5;
    reg_w(8'hF3, 8'h7C);
    idx_w(8'hFE); dat_r();
    cur_req = "R10";
    reg_r(8'hF4); reg_r(8'hF7);
    cur_req = "R8";
    wait_idle();
    reg_r(8'hF4); reg_r(8'hF5); reg_r(8'hF6); reg_r(8'hF7);

    cur_req = "R9";       // stray ack, zero-latency ack
    spur = 1; idle_wait(4); spur = 0; idle_wait(2);
    reg_r(8'hF4);
    lat = 0;
    reg_w(8'hF8, 8'h01); reg_w(8'hFE, 8'hCF); wait_idle();
    idx_w(8'hFE); dat_r(); wait_idle(); reg_r(8'hF6);

    cur_req = "R3";       // relock
    idx_w(8'hF5); idx_w(8'hAA); dat_r(); idx_r();
    idx_w(8'h07); dat_w(8'h00);
    idx_w(8'hA5); idx_w(8'hA5); idx_r(); dat_r();

    cur_req = "R11";
    idle_wait(5);

    finished = 1;
    summary();
    $finish;
  end

  task automatic idle_wait(int n);
    repeat (n) @(negedge clk);
  endtask
endmodule